// File: doc/BRIEF.md
# PCI Interrupt Routing Controller

This block gathers the bridge's internal interrupt sources and presents them on the four open-drain PCI interrupt lines, INTA to INTD. There are four internal sources: two DMA channel requests, a mailbox summary level and a request raised by the local processor. All four are merged onto the one line named by a 3-bit destination field. Each line can also be configured as an input. A synchronized input can then be forwarded, through a crosspoint of route bits, onto any line configured as an output, including the line that carries the internal requests.

Software on the PCI side and software on the local side share one register port, and a side-select input tells the block which of the two is writing. There are four registers:
- a status word, with write-one-to-clear request bits and pin-latch bits;
- a configuration word, holding the source enables, the mode fields and the route matrix;
- the destination-pin field;
- a local-side DMA status word.

The block never drives a line high. Each line has one active-low output enable, which pulls the line low while it is asserted.

Top module: `pci_irq_router`

## Requirements
- R1: A `dma_req[c]` pulse sets status bit c (address 0, bits 1:0). Writing 1 to that bit clears it. Writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R2: The local-side DMA status bits at address 3, bits 1:0, are set by the same pulses. They are cleared only by a local-side write of 1 to address 3. A PCI-side write to address 3 is ignored, and so is a clear at address 0.
- R3: Status bit 2 reads the live mailbox input. Writing to it has no effect.
- R4: Status bit 3 (local request) is set only by a local-side write with bit 8 = 1 to address 0. Either side clears it by writing 1 to bit 3, and a set in the same write wins. A PCI-side write to bit 8 is ignored.
- R5: The destination field (address 2, bits 2:0) selects the pin: 001=INTA, 010=INTB, 011=INTC, 100=INTD. The values 000 and 101 to 111 send the internal request to no pin.
- R6: The internal request is the OR of: DMA0 gated by config bit 0, DMA1 gated by bit 1, mailbox gated by bit 2, and the local request with no gate.
- R7: The mode of pin d sits at config bits [5+2d:4+2d]. Mode 00 is input, 01 is level output, 10 is software-cleared output and 11 is off. A pin in mode 00 or 11 never has its output enable asserted. Output enable is active low.
- R8: Pin inputs are active low and pass through two flip-flops. Status bits 7:4 show the synchronized asserted state. Route bit 16+4d+s forwards input pin s onto pin d, provided pin s is in mode 00. The forwarded input reaches pin d two clock edges after the input changes.
- R9: The drive on a pin is the OR of the internal request, when that pin is the destination, and every routed input.
- R10: In mode 10, pin d sets a sticky latch (status bit 12+d) whenever its source is active, and keeps the pin driven until a write of 1 to status bit 12+d clears the latch. Any other mode keeps the latch clear.
- R11: After reset all registers and synchronizer flops are zero, and all output enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_side | input | 1 | Writer: 0 = PCI side, 1 = local side |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| dma_req | input | 2 | DMA channel request pulses |
| mbox_irq | input | 1 | Mailbox summary level |
| intx_in | input | 4 | Sensed INTA..INTD pin levels, active low |
| intx_oe_n | output | 4 | Open-drain pull-down enables, active low |

## Verification
On every cycle the assertions check the following:
- the write-one-to-clear and set-priority rules of the DMA bits;
- that a PCI-side write can neither touch the local DMA status nor set the local request;
- that pins in input or off mode never drive;
- that a software-cleared latch both holds its pin and stays set until it is cleared.

Other behaviours can only be shown by the bench's scenarios, checked against its reference model:
- the full decode of the destination field;
- the two-edge synchronizer latency of routed inputs;
- the OR of internal and routed sources on a shared pin;
- the readback of every register.

// File: rtl/pci_irq_router.sv
module pci_irq_router (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_side,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [1:0]  dma_req,
  input  logic        mbox_irq,
  input  logic [3:0]  intx_in,
  output logic [3:0]  intx_oe_n
);
  localparam logic [31:0] CFG_MASK = 32'hFFFF_0FF7;

  logic [1:0]  dma_stat, lb_stat;
  logic        local_req;
  logic [31:0] cfg;
  logic [2:0]  pin_sel;
  logic [3:0]  sync1, sync2, latch;
  logic [3:0]  is_in, src, drive;
  logic        int_any;

  wire wr_stat = reg_we && reg_addr == 2'd0;
  wire wr_cfg  = reg_we && reg_addr == 2'd1;
  wire wr_sel  = reg_we && reg_addr == 2'd2;
  wire wr_lb   = reg_we && reg_addr == 2'd3 && reg_side;

  assign int_any = (dma_stat[0] & cfg[0]) | (dma_stat[1] & cfg[1]) |
                   (mbox_irq & cfg[2]) | local_req;

  for (genvar d = 0; d < 4; d++) begin : g_pin
    logic [1:0] mode;
    assign mode     = cfg[5+2*d -: 2];
    assign is_in[d] = mode == 2'b00;
    assign src[d]   = (int_any && pin_sel == 3'(d + 1)) |
                      (|(cfg[16+4*d +: 4] & is_in & sync2));
    assign drive[d] = (mode == 2'b01 && src[d]) ||
                      (mode == 2'b10 && (src[d] || latch[d]));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) latch[d] <= 1'b0;
      else latch[d] <= (mode == 2'b10) &&
                       (src[d] || (latch[d] && !(wr_stat && reg_wdata[12+d])));
  end

  assign intx_oe_n = ~drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_stat  <= '0;
      lb_stat   <= '0;
      local_req <= 1'b0;
      cfg       <= '0;
      pin_sel   <= '0;
      sync1     <= '0;
      sync2     <= '0;
    end else begin
      dma_stat  <= (dma_stat & ~(wr_stat ? reg_wdata[1:0] : 2'b00)) | dma_req;
      lb_stat   <= (lb_stat & ~(wr_lb ? reg_wdata[1:0] : 2'b00)) | dma_req;
      if (wr_stat && reg_side && reg_wdata[8]) local_req <= 1'b1;
      else if (wr_stat && reg_wdata[3])        local_req <= 1'b0;
      if (wr_cfg) cfg <= reg_wdata & CFG_MASK;
      if (wr_sel) pin_sel <= reg_wdata[2:0];
      sync1 <= ~intx_in;
      sync2 <= sync1;
    end
  end

  always_comb
    case (reg_addr)
      2'd0: reg_rdata = {16'b0, latch, 4'b0, sync2, local_req, mbox_irq, dma_stat};
      2'd1: reg_rdata = cfg;
      2'd2: reg_rdata = {29'b0, pin_sel};
      default: reg_rdata = {30'b0, lb_stat};
    endcase
endmodule

module irq_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic        reg_side,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [1:0]  dma_req,
  input logic [3:0]  intx_oe_n,
  input logic [31:0] cfg,
  input logic [1:0]  dma_stat,
  input logic [1:0]  lb_stat,
  input logic        local_req,
  input logic [3:0]  latch
);
  a_r1_dma_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0 && reg_wdata[0] && !dma_req[0]) |=> !dma_stat[0]);
  a_r1_dma_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req[0] |=> dma_stat[0]);
  a_r2_lb_pci_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_side && reg_addr == 2'd3 && dma_req == 2'b00) |=> $stable(lb_stat));
  a_r4_pci_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!local_req && !(reg_we && reg_side && reg_addr == 2'd0 && reg_wdata[8])) |=> !local_req);

  for (genvar d = 0; d < 4; d++) begin : g_chk
    a_r7_quiet_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[5+2*d -: 2] == 2'b00 || cfg[5+2*d -: 2] == 2'b11) |-> intx_oe_n[d]);
    a_r10_latch_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[5+2*d -: 2] == 2'b10 && latch[d]) |-> !intx_oe_n[d]);
    a_r10_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[5+2*d -: 2] == 2'b10 && latch[d] && !(reg_we && reg_addr == 2'd1) &&
       !(reg_we && reg_addr == 2'd0 && reg_wdata[12+d])) |=> latch[d]);
  end
endmodule

bind pci_irq_router irq_router_chk u_chk (.*);

// File: tb/pci_irq_router_tb.sv
module pci_irq_router_tb;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0, reg_side = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [1:0] dma_req = 0;
  logic mbox_irq = 0;
  logic [3:0] intx_in = 4'hF, intx_oe_n;

  pci_irq_router u_dut (.*);

  always #5 clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 0, comparing = 0;
  string tag = "R11";

  logic [1:0] m_dma = 0, m_lb = 0;
  logic m_local = 0;
  logic [31:0] m_cfg = 0;
  logic [2:0] m_sel = 0;
  logic [3:0] m_s1 = 0, m_s2 = 0, m_lat = 0;

  function automatic logic [1:0] mode_of(int d);
    return m_cfg[4+2*d +: 2];
  endfunction

  function automatic logic src_of(int d);
    logic r = 0;
    logic irq = (m_dma[0] && m_cfg[0]) || (m_dma[1] && m_cfg[1]) ||
                (mbox_irq && m_cfg[2]) || m_local;
    if (irq && m_sel == d + 1) r = 1;
    for (int s = 0; s < 4; s++)
      if (m_cfg[16+4*d+s] && mode_of(s) == 0 && m_s2[s]) r = 1;
    return r;
  endfunction

  function automatic logic [3:0] exp_oe_n();
    logic [3:0] o = 4'hF;
    for (int d = 0; d < 4; d++)
      if ((mode_of(d) == 1 && src_of(d)) || (mode_of(d) == 2 && (src_of(d) || m_lat[d])))
        o[d] = 0;
    return o;
  endfunction

  function automatic logic [31:0] exp_rdata();
    case (reg_addr)
      0: return {16'b0, m_lat, 4'b0, m_s2, m_local, mbox_irq, m_dma};
      1: return m_cfg;
      2: return {29'b0, m_sel};
      default: return {30'b0, m_lb};
    endcase
  endfunction

  task automatic model_step();
    logic [3:0] nl;
    for (int d = 0; d < 4; d++)
      nl[d] = mode_of(d) == 2 &&
              (src_of(d) || (m_lat[d] && !(reg_we && reg_addr == 0 && reg_wdata[12+d])));
    if (reg_we && reg_addr == 0) begin
      m_dma = m_dma & ~reg_wdata[1:0];
      if (reg_wdata[3]) m_local = 0;
      if (reg_side && reg_wdata[8]) m_local = 1;
    end
    if (reg_we && reg_addr == 3 && reg_side) m_lb = m_lb & ~reg_wdata[1:0];
    m_dma = m_dma | dma_req;
    m_lb = m_lb | dma_req;
    if (reg_we && reg_addr == 1) m_cfg = reg_wdata & 32'hFFFF_0FF7;
    if (reg_we && reg_addr == 2) m_sel = reg_wdata[2:0];
    m_s2 = m_s1;
    m_s1 = ~intx_in;
    m_lat = nl;
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    if (comparing) begin
      vectors++;
      if (intx_oe_n !== exp_oe_n()) begin
        errors++;
        $display("FAIL %s oe_n actual %b expected %b", tag, intx_oe_n, exp_oe_n());
      end
      vectors++;
      if (reg_rdata !== exp_rdata()) begin
        errors++;
        $display("FAIL %s rdata[%0d] actual %h expected %h", tag, reg_addr, reg_rdata, exp_rdata());
      end
    end
  endtask

  task automatic wr(input logic side, input logic [1:0] a, input logic [31:0] d);
    reg_we = 1; reg_side = side; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, input int n);
    reg_addr = a;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse(input logic [1:0] r);
    dma_req = r; tick(); dma_req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    comparing = 1;
    tag = "R11";
    for (int a = 0; a < 4; a++) rd(2'(a), 1);

    tag = "R1";
    rd(0, 0);
    pulse(2'b11); rd(0, 1);
    wr(0, 0, 32'h0); rd(0, 1);
    wr(0, 0, 32'h1); rd(0, 1);
    dma_req = 2'b10; wr(0, 0, 32'h2); dma_req = 0; rd(0, 1);
    wr(1, 0, 32'h3); rd(0, 1);

    tag = "R2";
    pulse(2'b11); rd(3, 1);
    wr(0, 0, 32'h3); rd(3, 1);
    wr(0, 3, 32'h3); rd(3, 1);
    wr(1, 3, 32'h1); rd(3, 1);
    wr(1, 3, 32'h2); rd(3, 1);

    tag = "R3";
    mbox_irq = 1; rd(0, 2);
    wr(0, 0, 32'h4); wr(1, 0, 32'h4); rd(0, 1);
    mbox_irq = 0; rd(0, 1);

    tag = "R4";
    wr(0, 0, 32'h100); rd(0, 1);
    wr(1, 0, 32'h100); rd(0, 1);
    wr(0, 0, 32'h8); rd(0, 1);
    wr(1, 0, 32'h100); wr(1, 0, 32'h8); rd(0, 1);
    wr(1, 0, 32'h108); rd(0, 1);
    wr(0, 0, 32'h8);

    tag = "R5";
    wr(0, 1, 32'h0000_0557);
    wr(1, 0, 32'h100);
    for (int s = 0; s < 8; s++) begin
      wr(0, 2, 32'(s)); rd(2, 2);
    end
    wr(0, 0, 32'h8);

    tag = "R6";
    wr(0, 2, 32'h1);
    wr(0, 1, 32'h0000_0550);
    pulse(2'b01); rd(0, 1);
    pulse(2'b10); mbox_irq = 1; rd(0, 1);
    wr(0, 1, 32'h0000_0551); rd(1, 1);
    wr(0, 0, 32'h1); rd(0, 1);
    wr(0, 1, 32'h0000_0552); rd(0, 1);
    wr(0, 1, 32'h0000_0554); rd(0, 1);
    mbox_irq = 0; wr(0, 0, 32'h3); rd(0, 1);

    tag = "R7";
    wr(1, 0, 32'h100);
    wr(0, 1, 32'h0000_00F0); rd(1, 2);
    wr(0, 1, 32'h0000_0000); rd(1, 2);
    wr(0, 0, 32'h8);

    tag = "R8";
    wr(0, 1, 32'h1000_0400);
    intx_in = 4'b1110; rd(0, 1); rd(0, 1); rd(0, 2);
    intx_in = 4'b1111; rd(0, 3);
    intx_in = 4'b1101; rd(0, 3);
    wr(0, 1, 32'h1000_0410); rd(0, 2);
    intx_in = 4'b1111; rd(0, 3);

    tag = "R9";
    wr(0, 1, 32'h1000_0407); wr(0, 2, 32'h4);
    pulse(2'b01); rd(0, 1);
    intx_in = 4'b1110; rd(0, 3);
    wr(0, 0, 32'h1); rd(0, 2);
    intx_in = 4'b1111; rd(0, 3);

    tag = "R10";
    wr(0, 1, 32'h1000_0807);
    pulse(2'b10); rd(0, 1);
    wr(0, 0, 32'h2); rd(0, 2);
    wr(0, 0, 32'h4000); rd(0, 2);
    wr(0, 0, 32'h8000); rd(0, 2);
    intx_in = 4'b1110; rd(0, 3);
    intx_in = 4'b1111; rd(0, 3);
    wr(0, 1, 32'h0000_0407); rd(0, 2);

    finish_run();
  end
endmodule